// File: doc/BRIEF.md
# Sentinel-Terminated Serial Transmitter

This block serializes words onto an asynchronous serial line. Software writes a 16-bit word into a holding register. The word carries the payload in its low bits, normally eight data bits in bits 7..0, with one or more 1 bits placed directly above the payload. When the shifter is free, the word moves at a bit boundary into a 16-bit shift register. The line then carries a low start bit, followed by the word least significant bit first. Each shift fills the top of the register with a zero.

No bit counter sets the frame length. The shifter halts as soon as its remaining contents are a single 1 in the output position with zeros everywhere above it. The highest 1 the user wrote therefore acts as the terminating sentinel, and it stays on the line as the mark level until the next frame. A writable divider sets the bit period, and every change on the line is aligned to that period. Two flags report whether the holding register and the shifter are free, so software can keep a second word queued behind the one on the line.

Top module: `sentx_top`

## Requirements
- R1: After reset the line `txd` is 1, `shift_empty` is 1, `hold_empty` is 1, and the divider holds the parameter `DIV_RST` (3 by default).
- R2: A write of a nonzero word loads the holding register, and `hold_empty` reads 0 on the next cycle. A second write made before the transfer replaces the pending word, so only the last word is sent.
- R3: A write whose data is all zeros is ignored. It does not change `hold_empty` and does not start a frame, and the line stays at 1.
- R4: The holding word moves to the shifter only at a bit boundary while `shift_empty` is 1. At that transfer `hold_empty` becomes 1 and `shift_empty` becomes 0.
- R5: A frame begins with one bit period of 0 (the start bit). The word's bits follow, bit 0 first.
- R6: The bits sent after the start bit are exactly the word bits below its highest 1. When the remaining contents equal 1, shifting stops, `shift_empty` becomes 1, and the line holds 1.
- R7: One bit period lasts divider+1 clock cycles, and `txd` changes only at period boundaries.
- R8: A divider write sets the period that later frames use.
- R9: A word queued during a frame starts exactly one bit period after that frame halts. The start of a word with highest 1 at index m is therefore followed by the next start (m+2) periods later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for the holding register |
| wr_data | input | 16 | Word to send, sentinel 1s above the payload |
| div_we | input | 1 | Write strobe for the divider |
| div_wdata | input | 16 | New divider value (period = value + 1 cycles) |
| txd | output | 1 | Serial output line, idles high |
| hold_empty | output | 1 | Holding register can accept a word |
| shift_empty | output | 1 | Shifter halted on its sentinel |

## Verification
Some properties are checked by assertions on every cycle. The line moves only on a period tick, and it is high whenever the shifter is halted. A frame starts with the line low and only when a word was pending. A zero write never empties or fills the holding register, and a nonzero write always fills it. Only the bench scenarios can show the frame contents and their order on the line, the bit period measured in cycles, the replacement of a pending word, and the exact spacing between back-to-back frames. The bench sweeps every byte value and many sentinel positions and divider settings.

// File: rtl/sentx_pkg.sv
package sentx_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_START = 2'd1,
    ST_SHIFT = 2'd2
  } sh_state_e;
endpackage

// File: rtl/sentx_baud.sv
module sentx_baud #(
  parameter int DIV_W   = 16,
  parameter int DIV_RST = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             div_we,
  input  logic [DIV_W-1:0] div_wdata,
  output logic             tick
);
  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] cnt_q;

  // end of a bit period: counter has reached (or passed, after a shrink) the divider
  function automatic logic period_done(input logic [DIV_W-1:0] c, input logic [DIV_W-1:0] d);
    return c >= d;
  endfunction

  assign tick = period_done(cnt_q, div_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_q <= DIV_W'(DIV_RST);
      cnt_q <= '0;
    end else begin
      if (div_we) div_q <= div_wdata;
      if (tick) cnt_q <= '0;
      else      cnt_q <= cnt_q + DIV_W'(1);
    end
  end
endmodule

// File: rtl/sentx_hold.sv
module sentx_hold #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         xfer,
  output logic [W-1:0] hold_q,
  output logic         hold_full,
  output logic         wr_accept
);
  // a word without any 1 has no sentinel and can never end a frame
  function automatic logic has_sentinel(input logic [W-1:0] v);
    return |v;
  endfunction

  assign wr_accept = wr_en && has_sentinel(wr_data);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_q    <= '0;
      hold_full <= 1'b0;
    end else if (wr_accept) begin
      hold_q    <= wr_data;
      hold_full <= 1'b1;
    end else if (xfer) begin
      hold_full <= 1'b0;
    end
  end
endmodule

// File: rtl/sentx_shift.sv
module sentx_shift
  import sentx_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         hold_full,
  input  logic [W-1:0] hold_q,
  output logic         xfer,
  output logic         txd,
  output logic         shift_empty
);
  sh_state_e    state_q;
  logic [W-1:0] sh_q;
  logic [W-1:0] sh_next;

  function automatic logic [W-1:0] shift_zero_fill(input logic [W-1:0] v);
    return {1'b0, v[W-1:1]};
  endfunction

  function automatic logic at_sentinel(input logic [W-1:0] v);
    return v == W'(1);
  endfunction

  assign sh_next     = shift_zero_fill(sh_q);
  assign xfer        = tick && (state_q == ST_IDLE) && hold_full;
  assign shift_empty = (state_q == ST_IDLE);
  assign txd         = (state_q == ST_START) ? 1'b0 : sh_q[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      sh_q    <= W'(1);
    end else if (tick) begin
      unique case (state_q)
        ST_IDLE: begin
          if (hold_full) begin
            sh_q    <= hold_q;
            state_q <= ST_START;
          end
        end
        ST_START: begin
          state_q <= at_sentinel(sh_q) ? ST_IDLE : ST_SHIFT;
        end
        ST_SHIFT: begin
          sh_q <= sh_next;
          if (at_sentinel(sh_next)) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sentx_top.sv
module sentx_top #(
  parameter int W       = 16,
  parameter int DIV_W   = 16,
  parameter int DIV_RST = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [W-1:0]     wr_data,
  input  logic             div_we,
  input  logic [DIV_W-1:0] div_wdata,
  output logic             txd,
  output logic             hold_empty,
  output logic             shift_empty
);
  logic         tick;
  logic         xfer;
  logic         hold_full;
  logic         wr_accept;
  logic [W-1:0] hold_q;

  sentx_baud #(.DIV_W(DIV_W), .DIV_RST(DIV_RST)) u_baud (
    .clk(clk), .rst_n(rst_n), .div_we(div_we), .div_wdata(div_wdata), .tick(tick)
  );

  sentx_hold #(.W(W)) u_hold (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .xfer(xfer),
    .hold_q(hold_q), .hold_full(hold_full), .wr_accept(wr_accept)
  );

  sentx_shift #(.W(W)) u_shift (
    .clk(clk), .rst_n(rst_n), .tick(tick), .hold_full(hold_full), .hold_q(hold_q),
    .xfer(xfer), .txd(txd), .shift_empty(shift_empty)
  );

  assign hold_empty = !hold_full;
endmodule

// File: rtl/sentx_chk.sv
module sentx_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         tick,
  input logic         xfer,
  input logic         wr_en,
  input logic         wr_accept,
  input logic [W-1:0] wr_data,
  input logic         txd,
  input logic         hold_empty,
  input logic         shift_empty
);
  // R7: line moves only right after a period tick
  p_line_on_tick_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(txd) |-> $past(tick));

  // R6: halted shifter keeps the mark level
  p_idle_mark_r6: assert property (@(posedge clk) disable iff (!rst_n)
    shift_empty |-> txd);

  // R5: a frame opens with the line low
  p_start_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(shift_empty) |-> !txd);

  // R4: shifter leaves idle only with a pending word, on a tick
  p_xfer_needs_word_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(shift_empty) |-> ($past(!hold_empty) && $past(tick)));

  // R4: transfer frees the holding register unless a new word lands at once
  p_xfer_frees_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && !wr_accept) |=> hold_empty);

  // R3: an all-zero write never fills the holding register
  p_zero_write_ignored_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (wr_data == '0) && hold_empty) |=> hold_empty);

  // R2: a nonzero write fills it
  p_write_fills_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (wr_data != '0)) |=> !hold_empty);
endmodule

bind sentx_top sentx_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .xfer(xfer), .wr_en(wr_en),
  .wr_accept(wr_accept), .wr_data(wr_data), .txd(txd),
  .hold_empty(hold_empty), .shift_empty(shift_empty)
);

// File: tb/tb_sentx_top.sv
`timescale 1ns/1ps
module tb_sentx_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic        div_we = 1'b0;
  logic [15:0] div_wdata = '0;
  logic        txd, hold_empty, shift_empty;

  int checks = 0;
  int errors = 0;
  longint cyc = 0;
  int cur_p = 4;
  bit done = 1'b0;

  sentx_top dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .div_we(div_we), .div_wdata(div_wdata),
    .txd(txd), .hold_empty(hold_empty), .shift_empty(shift_empty)
  );

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int top_one(input logic [15:0] w);
    int m = -1;
    for (int i = 0; i < 16; i++) if (w[i]) m = i;
    return m;
  endfunction

  task automatic wr_word(input logic [15:0] w);
    wr_en = 1'b1; wr_data = w;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic set_div(input int d);
    div_we = 1'b1; div_wdata = 16'(d);
    @(negedge clk);
    div_we = 1'b0;
    cur_p = d + 1;
  endtask

  task automatic wait_start(output longint t0);
    int guard = 0;
    while (txd !== 1'b0 && guard < 20000) begin @(negedge clk); guard++; end
    chk(guard < 20000, "R4", "start bit seen", guard, 0);
    t0 = cyc;
  endtask

  // receive one frame and compare with the word's bits below its sentinel
  task automatic rx_frame(input logic [15:0] w, output longint t0);
    int m = top_one(w);
    int p = cur_p;
    wait_start(t0);
    repeat ((p - 1) / 2) @(negedge clk);
    chk(txd == 1'b0, "R5", "start bit level", txd, 0);
    chk(shift_empty == 1'b0, "R4", "shifter busy in frame", shift_empty, 0);
    for (int i = 0; i < m; i++) begin
      repeat (p) @(negedge clk);
      chk(txd == w[i], "R5", $sformatf("bit %0d of %h", i, w), txd, w[i]);
    end
    repeat (p) @(negedge clk);
    chk(txd == 1'b1, "R6", "mark after sentinel", txd, 1);
    chk(shift_empty == 1'b1, "R6", "halted on sentinel", shift_empty, 1);
  endtask

  task automatic send_check(input logic [15:0] w);
    longint t;
    wr_word(w);
    rx_frame(w, t);
  endtask

  task automatic measure_start(input logic [15:0] w, input string req);
    longint t;
    int len = 0;
    wr_word(w);
    wait_start(t);
    while (txd == 1'b0 && len < 100000) begin @(negedge clk); len++; end
    chk(len == cur_p, req, "start bit length in cycles", len, cur_p);
    repeat (20 * cur_p) @(negedge clk);
  endtask

  initial begin
    longint ta, tb2, tdummy;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(txd == 1'b1, "R1", "txd at reset", txd, 1);
    chk(shift_empty == 1'b1, "R1", "shift_empty at reset", shift_empty, 1);
    chk(hold_empty == 1'b1, "R1", "hold_empty at reset", hold_empty, 1);
    rst_n = 1'b1;
    @(negedge clk);

    // R1/R8: reset divider 3 gives 4-cycle bits
    measure_start(16'h01FF, "R1");

    // R2: write fills the holding register
    wr_word(16'h0155);
    chk(hold_empty == 1'b0, "R2", "hold_empty after write", hold_empty, 0);
    rx_frame(16'h0155, tdummy);
    chk(hold_empty == 1'b1, "R4", "hold_empty after transfer", hold_empty, 1);

    // R3: all-zero write ignored
    wr_word(16'h0000);
    begin
      int lows = 0;
      for (int k = 0; k < 6 * cur_p; k++) begin
        @(negedge clk);
        if (txd == 1'b0) lows++;
      end
      chk(lows == 0, "R3", "line low cycles after zero write", lows, 0);
      chk(hold_empty == 1'b1, "R3", "hold_empty after zero write", hold_empty, 1);
      chk(shift_empty == 1'b1, "R3", "shift_empty after zero write", shift_empty, 1);
    end

    // R7/R8: start bit length follows the divider
    set_div(0); measure_start(16'h0003, "R7");
    set_div(2); measure_start(16'h0107, "R8");
    set_div(6); measure_start(16'h0181, "R7");

    // R5/R6: every byte with one sentinel, divider 1
    set_div(1);
    for (int d = 0; d < 256; d++) send_check(16'h0100 | 16'(d));

    // R6: nine data bits, two stop bits, divider 0
    set_div(0);
    for (int d = 0; d < 512; d += 7) send_check(16'h0600 | 16'(d));

    // R6: sentinel at every position, plus all ones, divider 4
    set_div(4);
    for (int k = 0; k < 16; k++) send_check(16'h0001 << k);
    send_check(16'hFFFF);
    send_check(16'h8001);

    // R9: queued word follows after exactly one mark period
    set_div(2);
    for (int k = 0; k < 3; k++) begin
      logic [15:0] a, b;
      a = (k == 0) ? 16'h01A5 : (k == 1) ? 16'h0001 : 16'h8000;
      b = 16'h0333;
      wr_word(a);
      fork
        begin rx_frame(a, ta); rx_frame(b, tb2); end
        begin
          while (hold_empty == 1'b0) @(negedge clk);
          wr_word(b);
        end
      join
      chk(tb2 - ta == longint'((top_one(a) + 2) * cur_p), "R9", "start to start cycles",
          tb2 - ta, (top_one(a) + 2) * cur_p);
    end

    // R2: pending word replaced before transfer
    begin
      wr_word(16'h01F0);
      fork
        begin rx_frame(16'h01F0, ta); rx_frame(16'h0133, tb2); end
        begin
          while (hold_empty == 1'b0) @(negedge clk);
          wr_word(16'h0111);
          wr_word(16'h0133);
        end
      join
      begin
        int lows = 0;
        for (int k = 0; k < 20 * cur_p; k++) begin
          @(negedge clk);
          if (txd == 1'b0) lows++;
        end
        chk(lows == 0, "R2", "no frame for replaced word", lows, 0);
      end
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule